// File: doc/BRIEF.md
# SD Host Interrupt and Status Register Slice

This block is the interrupt-facing part of an SD host controller's register file. It keeps the global control word, the raw interrupt status, the interrupt mask, the card status word, the DMA status word and the remaining-transfer byte counter. It also holds plain storage for the block size and timeout words. Software reaches every word through a 32-bit register port: one write strobe, one address and one write-data bus. Read data is registered.

The command engine, the card bus and the DMA engine are not part of this block. They report to it through single-cycle event pulses and through a transfer strobe that carries a byte count. The block merges these events into the status words. Software acknowledges events by writing ones. The block drives one registered, level-sensitive interrupt line that is gated by a global enable bit.

Register offsets: control 0x00, block size 0x04, timeout 0x08, byte count 0x0C, remaining count 0x10 (read-only), mask 0x14, masked status 0x18, raw status 0x1C, card status 0x20 (read-only), DMA status 0x24.

Top module: `sdh_irq_regs`

## Requirements
- R1: After reset the registers read as follows: control 0x300, block size 0x200, byte count 0x200, timeout 0xFFFFFF40, card status 0x100. Raw status, mask, DMA status and remaining count read 0, and `irq` is low.
- R2: A write to control stores the data, except bits 2:0 (reset requests), which always read back as zero.
- R3: Event pulses set raw status bits: no-response sets bit 1, command-done bit 2, data-done bit 3, auto-stop-done bit 14 and SDIO/DMA-done bit 16. Bench event map, bit 0 upward: cmd, no-resp, data, auto-stop, sdio, insert, remove, dma-tx, dma-rx.
- R4: The masked status reads as raw AND mask. A write to the masked or the raw status offset clears each raw bit where the data holds a one.
- R5: If an event pulse and a clearing write hit the same raw bit in the same cycle, the bit ends up set.
- R6: `irq` is registered. It is high one cycle after control bit 4 is set and raw AND mask is nonzero, and low otherwise.
- R7: Card insert sets raw bit 30, clears raw bit 31 and sets card status bit 8. Card remove does the reverse. When both arrive in one cycle, insert wins. Writes to card status have no effect.
- R8: DMA transmit-done sets DMA status bits 0 and 8, and receive-done sets bits 1 and 8. Writing ones clears bits only within 9:0. Bits 31:10 are unaffected by writes.
- R9: A write to byte count loads both the byte count and the remaining count. A write takes priority over a transfer in the same cycle, and that transfer sets no status.
- R10: A transfer of N bytes lowers the remaining count by N, saturating at zero. Any transfer whose result is zero sets raw bit 3.
- R11: Read data shows the word at `reg_addr` one cycle later. Block size and timeout store what is written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_cmd_done | input | 1 | Command complete pulse |
| ev_no_resp | input | 1 | No response pulse |
| ev_data_done | input | 1 | Data complete pulse |
| ev_autostop | input | 1 | Auto-stop done pulse |
| ev_sdio | input | 1 | SDIO / DMA done pulse |
| ev_card_ins | input | 1 | Card inserted pulse |
| ev_card_rem | input | 1 | Card removed pulse |
| ev_dma_tx | input | 1 | DMA transmit done pulse |
| ev_dma_rx | input | 1 | DMA receive done pulse |
| xfer_vld | input | 1 | Data transfer strobe |
| xfer_bytes | input | CNT_W | Bytes moved by the transfer |
| irq | output | 1 | Level interrupt output |

## Verification
The bench covers several kinds of stimulus:
- Single event pulses show each source landing on its own raw bit.
- A burst of four events followed by partial acknowledgements shows that clears touch only the written bits.
- Toggling the mask and the global enable while one event is pending separates the enable gate from the mask gate on `irq`.
- Transfers are tried in three ways: ones that stop above zero, one that lands exactly on zero, and one that starts at zero. These separate the decrement, the saturation and the completion flag.
- Same-cycle collisions show which side wins in each case: clear against event, insert against remove, and load against transfer.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

  localparam int REG_W = 32;

  // register byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_BLKSZ  = 'h04;
  localparam int OFS_TMO    = 'h08;
  localparam int OFS_BCNT   = 'h0C;
  localparam int OFS_REMAIN = 'h10;
  localparam int OFS_MASK   = 'h14;
  localparam int OFS_MSTAT  = 'h18;
  localparam int OFS_RSTAT  = 'h1C;
  localparam int OFS_CARD   = 'h20;
  localparam int OFS_DSTAT  = 'h24;

  // raw status bit positions (software decodes these)
  localparam int BIT_NO_RESP   = 1;
  localparam int BIT_CMD_DONE  = 2;
  localparam int BIT_DATA_DONE = 3;
  localparam int BIT_AUTOSTOP  = 14;
  localparam int BIT_SDIO      = 16;
  localparam int BIT_INSERT    = 30;
  localparam int BIT_REMOVE    = 31;

  // control and card status bits
  localparam int CTRL_IRQ_EN_BIT   = 4;
  localparam int CTRL_RST_REQ_W    = 3;
  localparam int CARD_PRESENT_BIT  = 8;

  // DMA status layout
  localparam int DSTAT_TX_BIT  = 0;
  localparam int DSTAT_RX_BIT  = 1;
  localparam int DSTAT_SUM_BIT = 8;
  localparam int DSTAT_CLR_W   = 10;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_BLKSZ, SEL_TMO, SEL_BCNT, SEL_REMAIN,
    SEL_MASK, SEL_MSTAT, SEL_RSTAT, SEL_CARD, SEL_DSTAT, SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/sdh_raw_stat.sv
// Raw status bits: each bit is set by an event, dropped by an opposing
// event, or cleared by a write-one; a set always beats a clear.
module sdh_raw_stat #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] drop_bits,
  output logic [W-1:0] raw
);

  logic [W-1:0] raw_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic kill;
    assign kill = (clr_we & clr_bits[i]) | drop_bits[i];
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[i] <= 1'b0;
      end else if (set_bits[i]) begin
        raw_q[i] <= 1'b1;
      end else if (kill) begin
        raw_q[i] <= 1'b0;
      end
    end
  end

  assign raw = raw_q;

endmodule

// File: rtl/sdh_dma_stat.sv
// DMA status word: transfer-direction events set their bit plus the
// summary bit; only the low CLR_W bits can be cleared by writing ones.
module sdh_dma_stat #(
  parameter int W       = 32,
  parameter int CLR_W   = 10,
  parameter int TX_BIT  = 0,
  parameter int RX_BIT  = 1,
  parameter int SUM_BIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_data,
  input  logic             tx_done,
  input  logic             rx_done,
  output logic [W-1:0]     stat
);

  logic [W-1:0] stat_q;
  logic [W-1:0] clr_vec;
  logic [W-1:0] set_vec;

  if (CLR_W < W) begin : g_partial
    assign clr_vec = clr_we ? {{(W-CLR_W){1'b0}}, clr_data} : '0;
  end else begin : g_full
    assign clr_vec = clr_we ? clr_data[W-1:0] : '0;
  end

  always_comb begin
    set_vec          = '0;
    set_vec[TX_BIT]  = tx_done;
    set_vec[RX_BIT]  = rx_done;
    set_vec[SUM_BIT] = tx_done | rx_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign stat = stat_q;

endmodule

// File: rtl/sdh_xfer_cnt.sv
// Remaining-transfer counter: load from software, count down per transfer,
// saturate at zero, flag every transfer that ends on zero.
module sdh_xfer_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             xfer_vld,
  input  logic [CNT_W-1:0] xfer_bytes,
  output logic [CNT_W-1:0] remain,
  output logic             hit_zero
);

  logic [CNT_W-1:0] remain_q;
  logic             covers;

  assign covers   = (remain_q <= xfer_bytes);
  assign hit_zero = xfer_vld & ~load & covers;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (xfer_vld) begin
      remain_q <= covers ? '0 : (remain_q - xfer_bytes);
    end
  end

  assign remain = remain_q;

endmodule

// File: rtl/sdh_irq_gen.sv
// Registered level interrupt: global enable AND any unmasked raw bit.
module sdh_irq_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  output logic         irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= enable & (|(raw & mask));
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs
  import sdh_irq_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              CNT_W     = 32,
  parameter logic [REG_W-1:0] CTRL_RST  = 32'h0000_0300,
  parameter logic [REG_W-1:0] BLKSZ_RST = 32'h0000_0200,
  parameter logic [REG_W-1:0] BCNT_RST  = 32'h0000_0200,
  parameter logic [REG_W-1:0] TMO_RST   = 32'hFFFF_FF40,
  parameter logic [REG_W-1:0] CARD_RST  = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_cmd_done,
  input  logic              ev_no_resp,
  input  logic              ev_data_done,
  input  logic              ev_autostop,
  input  logic              ev_sdio,
  input  logic              ev_card_ins,
  input  logic              ev_card_rem,
  input  logic              ev_dma_tx,
  input  logic              ev_dma_rx,
  input  logic              xfer_vld,
  input  logic [CNT_W-1:0]  xfer_bytes,
  output logic              irq
);

  localparam logic [REG_W-1:0] RST_REQ_MASK = REG_W'((1 << CTRL_RST_REQ_W) - 1);

  reg_sel_e         sel;
  logic [REG_W-1:0] ctrl_q, blksz_q, tmo_q, bcnt_q, mask_q, card_q;
  logic [REG_W-1:0] raw_q, dstat_q, rd_mux, rdata_q;
  logic [REG_W-1:0] ev_set, ev_drop;
  logic [CNT_W-1:0] remain_q;
  logic             bcnt_we, stat_clr_we, dstat_clr_we, xfer_zero;

  // address decode
  always_comb begin
    case (reg_addr)
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      ADDR_W'(OFS_BLKSZ):  sel = SEL_BLKSZ;
      ADDR_W'(OFS_TMO):    sel = SEL_TMO;
      ADDR_W'(OFS_BCNT):   sel = SEL_BCNT;
      ADDR_W'(OFS_REMAIN): sel = SEL_REMAIN;
      ADDR_W'(OFS_MASK):   sel = SEL_MASK;
      ADDR_W'(OFS_MSTAT):  sel = SEL_MSTAT;
      ADDR_W'(OFS_RSTAT):  sel = SEL_RSTAT;
      ADDR_W'(OFS_CARD):   sel = SEL_CARD;
      ADDR_W'(OFS_DSTAT):  sel = SEL_DSTAT;
      default:             sel = SEL_NONE;
    endcase
  end

  assign bcnt_we      = reg_we & (sel == SEL_BCNT);
  assign stat_clr_we  = reg_we & ((sel == SEL_MSTAT) | (sel == SEL_RSTAT));
  assign dstat_clr_we = reg_we & (sel == SEL_DSTAT);

  // software-owned words
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      blksz_q <= BLKSZ_RST;
      tmo_q   <= TMO_RST;
      bcnt_q  <= BCNT_RST;
      mask_q  <= '0;
    end else if (reg_we) begin
      case (sel)
        SEL_CTRL:  ctrl_q  <= reg_wdata & ~RST_REQ_MASK;
        SEL_BLKSZ: blksz_q <= reg_wdata;
        SEL_TMO:   tmo_q   <= reg_wdata;
        SEL_BCNT:  bcnt_q  <= reg_wdata;
        SEL_MASK:  mask_q  <= reg_wdata;
        default:   ;
      endcase
    end
  end

  // event merge into raw status; insert outranks remove
  always_comb begin
    ev_set                = '0;
    ev_drop               = '0;
    ev_set[BIT_NO_RESP]   = ev_no_resp;
    ev_set[BIT_CMD_DONE]  = ev_cmd_done;
    ev_set[BIT_DATA_DONE] = ev_data_done | xfer_zero;
    ev_set[BIT_AUTOSTOP]  = ev_autostop;
    ev_set[BIT_SDIO]      = ev_sdio;
    if (ev_card_ins) begin
      ev_set[BIT_INSERT]  = 1'b1;
      ev_drop[BIT_REMOVE] = 1'b1;
    end else if (ev_card_rem) begin
      ev_set[BIT_REMOVE]  = 1'b1;
      ev_drop[BIT_INSERT] = 1'b1;
    end
  end

  // card status word: hardware-owned, writes ignored
  always_ff @(posedge clk) begin
    if (rst) begin
      card_q <= CARD_RST;
    end else if (ev_card_ins) begin
      card_q[CARD_PRESENT_BIT] <= 1'b1;
    end else if (ev_card_rem) begin
      card_q[CARD_PRESENT_BIT] <= 1'b0;
    end
  end

  sdh_raw_stat #(.W(REG_W)) u_raw (
    .clk       (clk),
    .rst       (rst),
    .clr_we    (stat_clr_we),
    .clr_bits  (reg_wdata),
    .set_bits  (ev_set),
    .drop_bits (ev_drop),
    .raw       (raw_q)
  );

  sdh_dma_stat #(
    .W       (REG_W),
    .CLR_W   (DSTAT_CLR_W),
    .TX_BIT  (DSTAT_TX_BIT),
    .RX_BIT  (DSTAT_RX_BIT),
    .SUM_BIT (DSTAT_SUM_BIT)
  ) u_dstat (
    .clk      (clk),
    .rst      (rst),
    .clr_we   (dstat_clr_we),
    .clr_data (reg_wdata[DSTAT_CLR_W-1:0]),
    .tx_done  (ev_dma_tx),
    .rx_done  (ev_dma_rx),
    .stat     (dstat_q)
  );

  sdh_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (bcnt_we),
    .load_val   (CNT_W'(reg_wdata)),
    .xfer_vld   (xfer_vld),
    .xfer_bytes (xfer_bytes),
    .remain     (remain_q),
    .hit_zero   (xfer_zero)
  );

  sdh_irq_gen #(.W(REG_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .enable (ctrl_q[CTRL_IRQ_EN_BIT]),
    .raw    (raw_q),
    .mask   (mask_q),
    .irq    (irq)
  );

  // registered read path
  always_comb begin
    case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_BLKSZ:  rd_mux = blksz_q;
      SEL_TMO:    rd_mux = tmo_q;
      SEL_BCNT:   rd_mux = bcnt_q;
      SEL_REMAIN: rd_mux = REG_W'(remain_q);
      SEL_MASK:   rd_mux = mask_q;
      SEL_MSTAT:  rd_mux = raw_q & mask_q;
      SEL_RSTAT:  rd_mux = raw_q;
      SEL_CARD:   rd_mux = card_q;
      SEL_DSTAT:  rd_mux = dstat_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/sdh_irq_regs_chk.sv
module sdh_irq_regs_chk
  import sdh_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              ev_cmd_done,
  input logic              ev_card_ins,
  input logic              ev_dma_tx,
  input logic              ev_dma_rx,
  input logic              irq_en,
  input logic [REG_W-1:0]  raw_q,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  card_q,
  input logic [REG_W-1:0]  dstat_q,
  input logic [CNT_W-1:0]  remain_q,
  input logic              bcnt_we,
  input logic              irq
);

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

  assert_irq_source_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(raw_q & mask_q) != '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_done |=> raw_q[BIT_CMD_DONE]);

  assert_card_insert_R7: assert property (@(posedge clk) disable iff (rst)
    ev_card_ins |=> (raw_q[BIT_INSERT] && !raw_q[BIT_REMOVE] && card_q == 32'h0000_0100));

  assert_rst_req_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == ADDR_W'(OFS_CTRL)) |-> ((reg_rdata & 32'h7) == '0));

  assert_dma_summary_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_dma_tx || ev_dma_rx) |=> ((dstat_q & 32'h100) != '0));

  assert_dma_high_stable_R8: assert property (@(posedge clk) disable iff (rst)
    $stable(dstat_q >> DSTAT_CLR_W));

  assert_remain_no_rise_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(bcnt_we) |-> (remain_q <= $past(remain_q)));

endmodule

bind sdh_irq_regs sdh_irq_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .ev_cmd_done (ev_cmd_done),
  .ev_card_ins (ev_card_ins),
  .ev_dma_tx   (ev_dma_tx),
  .ev_dma_rx   (ev_dma_rx),
  .irq_en      (ctrl_q[4]),
  .raw_q       (raw_q),
  .mask_q      (mask_q),
  .card_q      (card_q),
  .dstat_q     (dstat_q),
  .remain_q    (remain_q),
  .bcnt_we     (bcnt_we),
  .irq         (irq)
);

// File: tb/tb_sdh_irq_regs.sv
module tb_sdh_irq_regs;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [7:0] A_CTRL = 8'h00, A_BLK = 8'h04, A_TMO = 8'h08, A_BCNT = 8'h0C;
  localparam logic [7:0] A_REM  = 8'h10, A_MASK = 8'h14, A_MST = 8'h18, A_RST = 8'h1C;
  localparam logic [7:0] A_CARD = 8'h20, A_DST = 8'h24;

  localparam logic [2:0] O_WR = 3'd0, O_RD = 3'd1, O_EV = 3'd2, O_XF = 3'd3, O_IRQ = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t TBL [NV] = '{
    '{O_WR, A_CTRL, 32'h317, 32'h0, 4'd2},      '{O_RD, A_CTRL, 32'h0, 32'h310, 4'd2},
    '{O_EV, 8'h0, 32'h001, 32'h0, 4'd3},        '{O_RD, A_RST, 32'h0, 32'h4, 4'd3},
    '{O_IRQ, 8'h0, 32'h0, 32'h0, 4'd6},
    '{O_WR, A_MASK, 32'h4, 32'h0, 4'd4},        '{O_RD, A_MST, 32'h0, 32'h4, 4'd4},
    '{O_IRQ, 8'h0, 32'h0, 32'h1, 4'd6},
    '{O_WR, A_CTRL, 32'h300, 32'h0, 4'd6},      '{O_IRQ, 8'h0, 32'h0, 32'h0, 4'd6},
    '{O_WR, A_CTRL, 32'h310, 32'h0, 4'd6},      '{O_IRQ, 8'h0, 32'h0, 32'h1, 4'd6},
    '{O_WR, A_MST, 32'h4, 32'h0, 4'd4},         '{O_RD, A_RST, 32'h0, 32'h0, 4'd4},
    '{O_EV, 8'h0, 32'h01E, 32'h0, 4'd3},        '{O_RD, A_RST, 32'h0, 32'h1400A, 4'd3},
    '{O_WR, A_MASK, 32'h10000, 32'h0, 4'd4},    '{O_RD, A_MST, 32'h0, 32'h10000, 4'd4},
    '{O_IRQ, 8'h0, 32'h0, 32'h1, 4'd6},
    '{O_WR, A_RST, 32'h4008, 32'h0, 4'd4},      '{O_RD, A_RST, 32'h0, 32'h10002, 4'd4},
    '{O_WR, A_RST, 32'hFFFFFFFF, 32'h0, 4'd4},  '{O_RD, A_RST, 32'h0, 32'h0, 4'd4},
    '{O_IRQ, 8'h0, 32'h0, 32'h0, 4'd6},
    '{O_EV, 8'h0, 32'h020, 32'h0, 4'd7},        '{O_RD, A_RST, 32'h0, 32'h40000000, 4'd7},
    '{O_RD, A_CARD, 32'h0, 32'h100, 4'd7},
    '{O_EV, 8'h0, 32'h040, 32'h0, 4'd7},        '{O_RD, A_RST, 32'h0, 32'h80000000, 4'd7},
    '{O_RD, A_CARD, 32'h0, 32'h0, 4'd7},
    '{O_WR, A_CARD, 32'hFFFFFFFF, 32'h0, 4'd7}, '{O_RD, A_CARD, 32'h0, 32'h0, 4'd7},
    '{O_EV, 8'h0, 32'h020, 32'h0, 4'd7},        '{O_RD, A_RST, 32'h0, 32'h40000000, 4'd7},
    '{O_RD, A_CARD, 32'h0, 32'h100, 4'd7},
    '{O_WR, A_RST, 32'h40000000, 32'h0, 4'd4},  '{O_RD, A_RST, 32'h0, 32'h0, 4'd4},
    '{O_EV, 8'h0, 32'h080, 32'h0, 4'd8},        '{O_RD, A_DST, 32'h0, 32'h101, 4'd8},
    '{O_EV, 8'h0, 32'h100, 32'h0, 4'd8},        '{O_RD, A_DST, 32'h0, 32'h103, 4'd8},
    '{O_WR, A_DST, 32'hFFFFFC00, 32'h0, 4'd8},  '{O_RD, A_DST, 32'h0, 32'h103, 4'd8},
    '{O_WR, A_DST, 32'h1, 32'h0, 4'd8},         '{O_RD, A_DST, 32'h0, 32'h102, 4'd8},
    '{O_WR, A_DST, 32'h3FF, 32'h0, 4'd8},       '{O_RD, A_DST, 32'h0, 32'h0, 4'd8},
    '{O_WR, A_BCNT, 32'h10, 32'h0, 4'd9},       '{O_RD, A_BCNT, 32'h0, 32'h10, 4'd9},
    '{O_RD, A_REM, 32'h0, 32'h10, 4'd9},
    '{O_XF, 8'h0, 32'h4, 32'h0, 4'd10},         '{O_RD, A_REM, 32'h0, 32'hC, 4'd10},
    '{O_RD, A_RST, 32'h0, 32'h0, 4'd10},
    '{O_XF, 8'h0, 32'h8, 32'h0, 4'd10},         '{O_RD, A_REM, 32'h0, 32'h4, 4'd10},
    '{O_XF, 8'h0, 32'h8, 32'h0, 4'd10},         '{O_RD, A_REM, 32'h0, 32'h0, 4'd10},
    '{O_RD, A_RST, 32'h0, 32'h8, 4'd10},
    '{O_WR, A_RST, 32'h8, 32'h0, 4'd10},        '{O_XF, 8'h0, 32'h4, 32'h0, 4'd10},
    '{O_RD, A_RST, 32'h0, 32'h8, 4'd10},        '{O_RD, A_REM, 32'h0, 32'h0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  ev = '0;
  logic        xfer_vld = 1'b0;
  logic [31:0] xfer_bytes = '0;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_irq_regs dut (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ev_cmd_done  (ev[0]),
    .ev_no_resp   (ev[1]),
    .ev_data_done (ev[2]),
    .ev_autostop  (ev[3]),
    .ev_sdio      (ev[4]),
    .ev_card_ins  (ev[5]),
    .ev_card_rem  (ev[6]),
    .ev_dma_tx    (ev[7]),
    .ev_dma_rx    (ev[8]),
    .xfer_vld     (xfer_vld),
    .xfer_bytes   (xfer_bytes),
    .irq          (irq)
  );

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // one cycle of stimulus: drive at negedge, commit at posedge, release at negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; ev = '0; xfer_vld = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    step();
    check(req, reg_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string req);
    step();
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(A_CTRL, 32'h300, "R1");
    rd(A_BLK,  32'h200, "R1");
    rd(A_TMO,  32'hFFFFFF40, "R1");
    rd(A_BCNT, 32'h200, "R1");
    rd(A_CARD, 32'h100, "R1");
    rd(A_RST,  32'h0, "R1");
    rd(A_MASK, 32'h0, "R1");
    rd(A_DST,  32'h0, "R1");
    rd(A_REM,  32'h0, "R1");
    irq_chk(1'b0, "R1");

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        O_WR:  wr(TBL[i].addr, TBL[i].data);
        O_RD:  rd(TBL[i].addr, TBL[i].exp, req_name(TBL[i].req));
        O_EV:  begin ev = TBL[i].data[8:0]; step(); end
        O_XF:  begin xfer_vld = 1'b1; xfer_bytes = TBL[i].data; step(); end
        O_IRQ: irq_chk(TBL[i].exp[0], req_name(TBL[i].req));
        default: ;
      endcase
    end

    // R11 storage and unmapped offsets
    wr(A_BLK, 32'h400);
    rd(A_BLK, 32'h400, "R11");
    wr(A_TMO, 32'h12345678);
    rd(A_TMO, 32'h12345678, "R11");
    rd(8'h30, 32'h0, "R11");

    // R5 clear and event on the same bit in one cycle
    wr(A_RST, 32'hFFFFFFFF);
    reg_we = 1'b1; reg_addr = A_RST; reg_wdata = 32'h4; ev = 9'h001;
    step();
    rd(A_RST, 32'h4, "R5");

    // R7 insert and remove together: insert wins
    wr(A_RST, 32'hFFFFFFFF);
    ev = 9'h060;
    step();
    rd(A_RST, 32'h40000000, "R7");
    rd(A_CARD, 32'h100, "R7");

    // R9 byte-count write and transfer in one cycle: write wins, no status
    wr(A_RST, 32'hFFFFFFFF);
    reg_we = 1'b1; reg_addr = A_BCNT; reg_wdata = 32'h20;
    xfer_vld = 1'b1; xfer_bytes = 32'h40;
    step();
    rd(A_REM, 32'h20, "R9");
    rd(A_RST, 32'h0, "R9");

    // R1 reset in mid-run
    ev = 9'h001;
    step();
    wr(A_MASK, 32'h4);
    irq_chk(1'b1, "R6");
    rst = 1'b1;
    step();
    rst = 1'b0;
    rd(A_CTRL, 32'h300, "R1");
    rd(A_RST, 32'h0, "R1");
    check("R1", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    finish_run();
  end

endmodule